// File: doc/BRIEF.md
# E1 Submultiframe CRC-4 Generator and Checker

This block computes the four-bit cyclic check over every eight-frame submultiframe of an E1 stream, in both directions at once. It takes one bit per cycle from a frame aligner, with a qualifier, the frame index within the submultiframe, and the bit index within the frame. On the transmit side it replaces the check-bit positions with the remainder of the previous submultiframe. On the receive side it gathers the check bits that arrive on the link and compares them with the remainder it computed locally over the previous submultiframe.

Each submultiframe is 8 frames of 256 bits. Frames with an even index carry the alignment word, and bit position 0 of those four frames holds one check bit. Before division, the bit string of the submultiframe is multiplied by x^4, with every check-bit position taken as zero. The divisor is x^4 + x + 1. The remainder for one submultiframe travels in the next submultiframe. A mismatch gives a one-cycle error pulse, suitable for driving far-end error reporting, and increments a saturating counter.

Each direction has its own control state machine with four states. OFF: checking is disabled. SYNC: enabled, waiting for the start of a submultiframe. FIRST: accumulating the first submultiframe, with no remainder yet. CHECK: a remainder from the previous submultiframe is held and is inserted or compared. The transitions are as follows. OFF→FIRST when enable is high on a valid first bit of a submultiframe. OFF→SYNC when enable is high on any other cycle. SYNC→FIRST on a valid first bit. FIRST→CHECK on a valid last bit. Every state returns to OFF when enable falls.

Top module: `e1_crc4_unit`

## Requirements
- R1: On transmit, in CHECK, bit position 0 of frames 0, 2, 4 and 6 of a submultiframe carries C1, C2, C3 and C4. These are the remainder bits x^3 down to x^0 of (previous submultiframe · x^4) mod (x^4 + x + 1). The first bit in time is the highest-order coefficient.
- R2: The values present at the four check-bit positions, on either input stream, have no effect on the computed remainder. They are taken as zero.
- R3: `tx_line_bit` equals `tx_bit` on every cycle that is not a check-bit position being filled in the CHECK state. This includes every cycle while `crc_en` is low.
- R4: In CHECK, `rx_checked` pulses for one cycle in the cycle after the accepted last bit (frame 7, position 255). `rx_crc_err` pulses in the same cycle if the four received check bits differ from the remainder of the previous submultiframe.
- R5: The first submultiframe accumulated after enabling produces no receive check. Its transmit check-bit positions pass `tx_bit` through unchanged.
- R6: If enable rises after bit 0 of a submultiframe, that submultiframe is not accumulated. Accumulation starts at the next frame 0, position 0.
- R7: While `crc_en` is low, no check pulse occurs and the stored remainder is discarded. Re-enabling restarts at R5.
- R8: Cycles with the valid input low are ignored, whatever frame, position and data they carry.
- R9: `rx_err_cnt` increments by one per error pulse and holds at 2^CNT_W−1.
- R10: After reset, the pulses and the counter are zero and the transmit stream passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crc_en | input | 1 | Enables check generation and checking |
| tx_valid | input | 1 | Transmit bit qualifier |
| tx_frame | input | 3 | Transmit frame index within the submultiframe |
| tx_bitpos | input | 8 | Transmit bit index within the frame |
| tx_bit | input | 1 | Transmit data bit |
| tx_line_bit | output | 1 | Transmit bit with check bits inserted |
| rx_valid | input | 1 | Receive bit qualifier |
| rx_frame | input | 3 | Receive frame index within the submultiframe |
| rx_bitpos | input | 8 | Receive bit index within the frame |
| rx_bit | input | 1 | Receive data bit |
| rx_checked | output | 1 | One-cycle pulse: a submultiframe was compared |
| rx_crc_err | output | 1 | One-cycle pulse: the comparison failed |
| rx_err_cnt | output | CNT_W (10) | Saturating count of failed comparisons |

## Verification
The assertions assume that the frame and bit indices of valid cycles advance without gaps, so that a last-bit marker is always followed by a first-bit marker. They also assume that `crc_en` changes only between valid bits. The bench drives one continuous, ordered index sequence for both directions. It changes enable only at a chosen bit's drive point. The garbage it inserts, including last-bit markers, goes only into cycles with valid low.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SYNC  = 2'd1,
        ST_FIRST = 2'd2,
        ST_CHECK = 2'd3
    } crc_state_t;

    localparam int unsigned DIR_COUNT = 2;
    localparam int unsigned DIR_TX    = 0;
    localparam int unsigned DIR_RX    = 1;

endpackage

// File: rtl/e1crc_slot_decode.sv
module e1crc_slot_decode #(
    parameter int unsigned BITS_PER_FRAME = 256,
    parameter int unsigned SMF_FRAMES     = 8,
    parameter int unsigned BIT_W          = $clog2(BITS_PER_FRAME),
    parameter int unsigned FRM_W          = $clog2(SMF_FRAMES)
) (
    input  logic [BIT_W-1:0] bitpos,
    input  logic [FRM_W-1:0] frame,
    output logic             smf_first,
    output logic             smf_last,
    output logic             c_slot,
    output logic [FRM_W-2:0] c_idx
);

    localparam logic [BIT_W-1:0] LAST_POS   = BIT_W'(BITS_PER_FRAME - 1);
    localparam logic [FRM_W-1:0] LAST_FRAME = FRM_W'(SMF_FRAMES - 1);

    always_comb begin
        smf_first = (bitpos == '0) && (frame == '0);
        smf_last  = (bitpos == LAST_POS) && (frame == LAST_FRAME);
        // check bits sit at position 0 of the alignment-word (even) frames
        c_slot    = (bitpos == '0) && !frame[0];
        c_idx     = frame[FRM_W-1:1];
    end

endmodule

// File: rtl/e1crc_fsm.sv
module e1crc_fsm
    import e1crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic valid,
    input  logic smf_first,
    input  logic smf_last,
    output logic run,
    output logic wrap,
    output logic idle,
    output logic armed
);

    crc_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en) begin
                    state_nxt = (valid && smf_first) ? ST_FIRST : ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (!en) begin
                    state_nxt = ST_OFF;
                end else if (valid && smf_first) begin
                    state_nxt = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (!en) begin
                    state_nxt = ST_OFF;
                end else if (valid && smf_last) begin
                    state_nxt = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!en) begin
                    state_nxt = ST_OFF;
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        run   = 1'b0;
        idle  = 1'b1;
        armed = 1'b0;
        unique case (state)
            ST_OFF, ST_SYNC: begin
                run  = en && valid && smf_first;
                idle = 1'b1;
            end
            ST_FIRST: begin
                run  = en && valid;
                idle = !en;
            end
            ST_CHECK: begin
                run   = en && valid;
                idle  = !en;
                armed = en;
            end
            default: begin
                run  = 1'b0;
                idle = 1'b1;
            end
        endcase
        wrap = run && smf_last;
    end

endmodule

// File: rtl/e1crc_accum.sv
module e1crc_accum #(
    parameter int unsigned     CRC_W = 4,
    parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             wrap,
    input  logic             din,
    output logic [CRC_W-1:0] hold
);

    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] acc_nxt;
    logic             fb;

    // serial division with the x^CRC_W pre-multiplication folded into feedback
    always_comb begin
        fb      = acc[CRC_W-1] ^ din;
        acc_nxt = {acc[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            hold <= '0;
        end else if (step) begin
            if (wrap) begin
                hold <= acc_nxt;
                acc  <= '0;
            end else begin
                acc  <= acc_nxt;
            end
        end else if (clr) begin
            acc <= '0;
        end
    end

endmodule

// File: rtl/e1crc_rxcheck.sv
module e1crc_rxcheck #(
    parameter int unsigned CRC_W  = 4,
    parameter int unsigned CIDX_W = $clog2(CRC_W),
    parameter int unsigned CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [CIDX_W-1:0] c_idx,
    input  logic              bit_in,
    input  logic              chk,
    input  logic [CRC_W-1:0]  ref_rem,
    output logic              checked,
    output logic              err,
    output logic [CNT_W-1:0]  cnt
);

    logic [CRC_W-1:0]  rcv;
    logic [CIDX_W-1:0] pos;

    // C1 arrives first and is the highest-order remainder bit
    assign pos = CIDX_W'(CRC_W - 1) - c_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcv     <= '0;
            checked <= 1'b0;
            err     <= 1'b0;
            cnt     <= '0;
        end else begin
            checked <= 1'b0;
            err     <= 1'b0;
            if (cap) begin
                rcv[pos] <= bit_in;
            end
            if (chk) begin
                checked <= 1'b1;
                if (rcv != ref_rem) begin
                    err <= 1'b1;
                    if (cnt != '1) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/e1_crc4_unit.sv
module e1_crc4_unit
    import e1crc_pkg::*;
#(
    parameter int unsigned      BITS_PER_FRAME = 256,
    parameter int unsigned      CRC_W          = 4,
    parameter logic [CRC_W-1:0] POLY           = 4'b0011,
    parameter int unsigned      CNT_W          = 10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   crc_en,
    input  logic                                   tx_valid,
    input  logic [$clog2(2*CRC_W)-1:0]             tx_frame,
    input  logic [$clog2(BITS_PER_FRAME)-1:0]      tx_bitpos,
    input  logic                                   tx_bit,
    output logic                                   tx_line_bit,
    input  logic                                   rx_valid,
    input  logic [$clog2(2*CRC_W)-1:0]             rx_frame,
    input  logic [$clog2(BITS_PER_FRAME)-1:0]      rx_bitpos,
    input  logic                                   rx_bit,
    output logic                                   rx_checked,
    output logic                                   rx_crc_err,
    output logic [CNT_W-1:0]                       rx_err_cnt
);

    localparam int unsigned SMF_FRAMES = 2 * CRC_W;
    localparam int unsigned FRM_W      = $clog2(SMF_FRAMES);
    localparam int unsigned BIT_W      = $clog2(BITS_PER_FRAME);
    localparam int unsigned CIDX_W     = FRM_W - 1;

    logic [DIR_COUNT-1:0]             d_valid, d_bit;
    logic [DIR_COUNT-1:0][FRM_W-1:0]  d_frame;
    logic [DIR_COUNT-1:0][BIT_W-1:0]  d_pos;
    logic [DIR_COUNT-1:0]             d_first, d_last, d_slot;
    logic [DIR_COUNT-1:0][CIDX_W-1:0] d_idx;
    logic [DIR_COUNT-1:0]             d_run, d_wrap, d_idle, d_armed;
    logic [DIR_COUNT-1:0][CRC_W-1:0]  d_hold;

    assign d_valid = {rx_valid, tx_valid};
    assign d_bit   = {rx_bit, tx_bit};
    assign d_frame = {rx_frame, tx_frame};
    assign d_pos   = {rx_bitpos, tx_bitpos};

    for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
        e1crc_slot_decode #(
            .BITS_PER_FRAME (BITS_PER_FRAME),
            .SMF_FRAMES     (SMF_FRAMES),
            .BIT_W          (BIT_W),
            .FRM_W          (FRM_W)
        ) u_dec (
            .bitpos    (d_pos[d]),
            .frame     (d_frame[d]),
            .smf_first (d_first[d]),
            .smf_last  (d_last[d]),
            .c_slot    (d_slot[d]),
            .c_idx     (d_idx[d])
        );

        e1crc_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (crc_en),
            .valid     (d_valid[d]),
            .smf_first (d_first[d]),
            .smf_last  (d_last[d]),
            .run       (d_run[d]),
            .wrap      (d_wrap[d]),
            .idle      (d_idle[d]),
            .armed     (d_armed[d])
        );

        e1crc_accum #(
            .CRC_W (CRC_W),
            .POLY  (POLY)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (d_idle[d]),
            .step  (d_run[d]),
            .wrap  (d_wrap[d]),
            .din   (d_slot[d] ? 1'b0 : d_bit[d]),
            .hold  (d_hold[d])
        );
    end

    logic [CIDX_W-1:0] tx_sel;
    assign tx_sel      = CIDX_W'(CRC_W - 1) - d_idx[DIR_TX];
    assign tx_line_bit = (d_armed[DIR_TX] && d_slot[DIR_TX]) ? d_hold[DIR_TX][tx_sel] : tx_bit;

    e1crc_rxcheck #(
        .CRC_W  (CRC_W),
        .CIDX_W (CIDX_W),
        .CNT_W  (CNT_W)
    ) u_rxchk (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (d_run[DIR_RX] && d_slot[DIR_RX]),
        .c_idx   (d_idx[DIR_RX]),
        .bit_in  (rx_bit),
        .chk     (d_wrap[DIR_RX] && d_armed[DIR_RX]),
        .ref_rem (d_hold[DIR_RX]),
        .checked (rx_checked),
        .err     (rx_crc_err),
        .cnt     (rx_err_cnt)
    );

endmodule

// File: rtl/e1_crc4_unit_chk.sv
module e1_crc4_unit_chk #(
    parameter int unsigned BITS_PER_FRAME = 256,
    parameter int unsigned CRC_W          = 4,
    parameter int unsigned CNT_W          = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              crc_en,
    input logic [$clog2(2*CRC_W)-1:0]        tx_frame,
    input logic [$clog2(BITS_PER_FRAME)-1:0] tx_bitpos,
    input logic                              tx_bit,
    input logic                              tx_line_bit,
    input logic                              rx_valid,
    input logic [$clog2(2*CRC_W)-1:0]        rx_frame,
    input logic [$clog2(BITS_PER_FRAME)-1:0] rx_bitpos,
    input logic                              rx_checked,
    input logic                              rx_crc_err,
    input logic [CNT_W-1:0]                  rx_err_cnt
);

    localparam int unsigned FRM_W = $clog2(2 * CRC_W);
    localparam int unsigned BIT_W = $clog2(BITS_PER_FRAME);
    localparam logic [FRM_W-1:0] LASTF = FRM_W'(2 * CRC_W - 1);
    localparam logic [BIT_W-1:0] LASTB = BIT_W'(BITS_PER_FRAME - 1);
    localparam logic [CNT_W-1:0] CMAX  = '1;

    // R4
    err_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_checked |-> $past(rx_valid && rx_frame == LASTF && rx_bitpos == LASTB));

    // R4
    err_with_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_err |-> rx_checked);

    // R3
    tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_line_bit != tx_bit) |-> (crc_en && tx_bitpos == '0 && !tx_frame[0]));

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(crc_en) |-> !rx_checked);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> !rx_checked);

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_cnt != $past(rx_err_cnt)) |->
            (rx_crc_err && rx_err_cnt == CNT_W'($past(rx_err_cnt) + 1'b1)));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_err_cnt) == CMAX) |-> (rx_err_cnt == CMAX));

endmodule

bind e1_crc4_unit e1_crc4_unit_chk #(
    .BITS_PER_FRAME (BITS_PER_FRAME),
    .CRC_W          (CRC_W),
    .CNT_W          (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .crc_en      (crc_en),
    .tx_frame    (tx_frame),
    .tx_bitpos   (tx_bitpos),
    .tx_bit      (tx_bit),
    .tx_line_bit (tx_line_bit),
    .rx_valid    (rx_valid),
    .rx_frame    (rx_frame),
    .rx_bitpos   (rx_bitpos),
    .rx_checked  (rx_checked),
    .rx_crc_err  (rx_crc_err),
    .rx_err_cnt  (rx_err_cnt)
);

// File: tb/e1_crc4_unit_tb.sv
`timescale 1ns/1ps
module e1_crc4_unit_tb;

    localparam int BPF      = 256;
    localparam int SMF_BITS = 2048;
    localparam int CNT_W    = 2;
    localparam int CNT_MAX  = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n, crc_en;
    logic             tx_valid, tx_bit, tx_line_bit;
    logic [2:0]       tx_frame, rx_frame;
    logic [7:0]       tx_bitpos, rx_bitpos;
    logic             rx_valid, rx_bit, rx_checked, rx_crc_err;
    logic [CNT_W-1:0] rx_err_cnt;

    e1_crc4_unit #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en),
        .tx_valid(tx_valid), .tx_frame(tx_frame), .tx_bitpos(tx_bitpos),
        .tx_bit(tx_bit), .tx_line_bit(tx_line_bit),
        .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_bitpos(rx_bitpos),
        .rx_bit(rx_bit), .rx_checked(rx_checked), .rx_crc_err(rx_crc_err),
        .rx_err_cnt(rx_err_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit         smf_d [SMF_BITS];
    logic [3:0] exp_prev = 4'h0;
    bit         have_prev = 1'b0;
    int         exp_cnt = 0;
    logic [15:0] prbs = 16'hACE1;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    function automatic bit next_bit();
        bit b;
        b = prbs[0];
        prbs = {1'b0, prbs[15:1]} ^ (b ? 16'hB400 : 16'h0000);
        return b;
    endfunction

    function automatic bit is_cslot(input int i);
        return ((i % BPF) == 0) && (((i / BPF) % 2) == 0);
    endfunction

    // long division of (message * x^4) by x^4 + x + 1, check positions as zero (R2)
    function automatic logic [3:0] ref_crc();
        logic [4:0] r;
        bit b;
        r = 5'd0;
        for (int i = 0; i < SMF_BITS + 4; i++) begin
            if (i < SMF_BITS) b = is_cslot(i) ? 1'b0 : smf_d[i];
            else              b = 1'b0;
            r = {r[3:0], b};
            if (r[4]) r = r ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    // one submultiframe on both streams; en_at = bit index where enable rises
    task automatic run_smf(input bit en, input int en_at, input logic [3:0] flip,
                           input bit gaps, input string tag);
        bit sync_ok, ins, exp_chk, exp_err;
        logic [3:0] rxc;
        int slot_bad, pass_bad, stray;
        sync_ok  = en && (en_at == 0);
        ins      = sync_ok && have_prev;
        exp_chk  = ins;
        exp_err  = ins && (flip != 4'h0);
        slot_bad = 0;
        pass_bad = 0;
        stray    = 0;
        for (int i = 0; i < SMF_BITS; i++) smf_d[i] = next_bit();
        rxc = (ins ? exp_prev : {next_bit(), next_bit(), next_bit(), next_bit()}) ^ flip;
        for (int i = 0; i < SMF_BITS; i++) begin
            if (gaps && (i % 97) == 5) begin
                @(negedge clk);
                tx_valid = 1'b0; rx_valid = 1'b0;
                tx_frame = 3'd7; rx_frame = 3'd7;
                tx_bitpos = 8'd255; rx_bitpos = 8'd255;
                tx_bit = next_bit(); rx_bit = next_bit();
                #1;
                if (rx_checked !== 1'b0 || rx_crc_err !== 1'b0) stray++;
            end
            @(negedge clk);
            if (en && i == en_at) crc_en = 1'b1;
            if (!en && i == 0)    crc_en = 1'b0;
            tx_valid  = 1'b1;
            rx_valid  = 1'b1;
            tx_frame  = 3'(i / BPF);
            rx_frame  = 3'(i / BPF);
            tx_bitpos = 8'(i % BPF);
            rx_bitpos = 8'(i % BPF);
            tx_bit    = is_cslot(i) ? next_bit() : smf_d[i];
            rx_bit    = is_cslot(i) ? rxc[3 - (i / BPF) / 2] : smf_d[i];
            #1;
            if (is_cslot(i)) begin
                if (tx_line_bit !== (ins ? exp_prev[3 - (i / BPF) / 2] : tx_bit)) slot_bad++;
            end else if (tx_line_bit !== tx_bit) begin
                pass_bad++;
            end
            if (i > 0 && (rx_checked !== 1'b0 || rx_crc_err !== 1'b0)) stray++;
        end
        @(posedge clk);
        #1;
        if (ins) chk(slot_bad == 0, {"R1 R2 tx check bits ", tag}, slot_bad, 0);
        else     chk(slot_bad == 0, {"R5 R7 tx check slots pass through ", tag}, slot_bad, 0);
        chk(pass_bad == 0, {"R3 tx data pass through ", tag}, pass_bad, 0);
        chk(stray == 0, {"R8 no pulse away from boundary ", tag}, stray, 0);
        if (en && en_at != 0)
            chk(rx_checked === exp_chk, {"R6 mid-start not checked ", tag}, int'(rx_checked), int'(exp_chk));
        else
            chk(rx_checked === exp_chk, {"R4 R5 rx_checked ", tag}, int'(rx_checked), int'(exp_chk));
        chk(rx_crc_err === exp_err, {"R4 rx_crc_err ", tag}, int'(rx_crc_err), int'(exp_err));
        if (exp_err && exp_cnt < CNT_MAX) exp_cnt++;
        chk(int'(rx_err_cnt) == exp_cnt, {"R9 err count ", tag}, int'(rx_err_cnt), exp_cnt);
        if (sync_ok) exp_prev = ref_crc();
        have_prev = sync_ok;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; crc_en = 1'b0;
        tx_valid = 1'b0; rx_valid = 1'b0;
        tx_frame = '0; rx_frame = '0; tx_bitpos = '0; rx_bitpos = '0;
        tx_bit = 1'b1; rx_bit = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(rx_checked === 1'b0 && rx_crc_err === 1'b0, "R10 pulses low in reset",
            int'(rx_checked), 0);
        chk(rx_err_cnt === '0, "R10 counter zero in reset", int'(rx_err_cnt), 0);
        chk(tx_line_bit === 1'b1, "R10 tx passes in reset", int'(tx_line_bit), 1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_disabled();
        run_smf(1'b0, 0, 4'hF, 1'b0, "disabled");
    endtask

    task automatic t_clean();
        run_smf(1'b1, 0, 4'hA, 1'b0, "first after enable");
        run_smf(1'b1, 0, 4'h0, 1'b0, "clean a");
        run_smf(1'b1, 0, 4'h0, 1'b0, "clean b");
    endtask

    task automatic t_errors();
        run_smf(1'b1, 0, 4'h8, 1'b0, "C1 flipped");
        run_smf(1'b1, 0, 4'h1, 1'b0, "C4 flipped");
        run_smf(1'b1, 0, 4'h0, 1'b0, "clean after errors");
    endtask

    task automatic t_gaps();
        run_smf(1'b1, 0, 4'h0, 1'b1, "gaps clean");
        run_smf(1'b1, 0, 4'h6, 1'b1, "gaps errored");
    endtask

    task automatic t_midstart();
        run_smf(1'b0, 0, 4'h0, 1'b0, "off before mid-start");
        run_smf(1'b1, 1000, 4'h3, 1'b0, "enable at bit 1000");
        run_smf(1'b1, 0, 4'h5, 1'b0, "first full after mid-start");
        run_smf(1'b1, 0, 4'h0, 1'b0, "checked after mid-start");
    endtask

    task automatic t_saturate();
        run_smf(1'b1, 0, 4'hF, 1'b0, "sat 1");
        run_smf(1'b1, 0, 4'h2, 1'b0, "sat 2");
        run_smf(1'b1, 0, 4'h4, 1'b0, "sat 3");
    endtask

    task automatic t_restart();
        run_smf(1'b0, 0, 4'h9, 1'b0, "disabled with bad bits");
        run_smf(1'b1, 0, 4'h9, 1'b0, "restart first");
        run_smf(1'b1, 0, 4'h0, 1'b0, "restart checked");
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_clean();
        t_errors();
        t_gaps();
        t_midstart();
        t_saturate();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule